// File: doc/BRIEF.md
# Three-Leg Half-Bridge Gate Sequencer

This block turns requested switch states for three half-bridge legs into high-side and low-side gate enables. Each leg is handled on its own, so a leg can act as a high-side switch, a low-side switch, or as one half of an H-bridge. Two legs together give the four bridge states: forward, reverse, brake and high impedance. Whenever a leg hands over from one switch to the other, the block holds both switches off for a programmable number of clock cycles before turning the incoming switch on.

Protection inputs can force gates off. Undervoltage on either supply, or overvoltage while the overvoltage lockout enable is set, turns every switch off. A per-leg kill input from the fault logic turns off only that leg. None of these inputs changes the requested state, so the gates come back by themselves once the condition clears. A handover after the lockout still obeys the dead time.

Gate outputs are registered, so a change in request or qualifier shows at the outputs one clock edge later. The dead time `DEAD_CYC` is derived from `CLK_HZ` and `DEAD_NS`, and it is at least one cycle. With the defaults, 50 MHz and 1000 ns, it is 50 cycles.

Top module: `hb_gate_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no request, every gate enable is 0.
- R2: No leg ever has its high-side and low-side enables at 1 in the same cycle.
- R3: After a leg's low-side enable falls at a clock edge, its high-side enable cannot rise before the DEAD_CYC-th following edge. A pending high-side request rises on exactly that edge.
- R4: After a leg's high-side enable falls at a clock edge, its low-side enable cannot rise before the DEAD_CYC-th following edge. A pending low-side request rises on exactly that edge.
- R5: A turn-off, or a turn-on whose opposite switch has been quiet for at least DEAD_CYC edges, appears on the first clock edge after the request changes.
- R6: If either undervoltage input (`uv_logic_i` or `uv_drv_i`) is 1, all gate enables are 0 from the next edge on.
- R7: If `ov_i` and `ov_lock_en_i` are both 1, all gate enables are 0 from the next edge on. When `ov_lock_en_i` is 0, `ov_i` has no effect on the gates.
- R8: When a global lockout (R6, R7) ends, each leg's gates return to the still-held requested state without any new request, subject to R3 and R4.
- R9: Asserting `leg_kill_i[k]` turns off both switches of leg k on the next edge, with no dead-time wait. The other legs are not affected.
- R10: If a leg requests both switches at once, the low-side request is ignored: only the high side may be on.
- R11: The three legs sequence independently. Each leg's dead-time timing depends only on its own gate history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_hs_i | input | N_LEGS | Requested high-side state per leg (1 = on) |
| req_ls_i | input | N_LEGS | Requested low-side state per leg (1 = on) |
| uv_logic_i | input | 1 | Logic supply undervoltage flag |
| uv_drv_i | input | 1 | Driver supply undervoltage flag |
| ov_i | input | 1 | Driver supply overvoltage flag |
| ov_lock_en_i | input | 1 | Overvoltage lockout enable |
| leg_kill_i | input | N_LEGS | Per-leg force-off from the fault logic |
| gate_hs_o | output | N_LEGS | High-side gate enable per leg |
| gate_ls_o | output | N_LEGS | Low-side gate enable per leg |

## Verification
The assertions assume that every input is synchronous to `clk_i` and stable around the sampling edge. They also assume that `DEAD_CYC` is at least one cycle, so that a handover needs at least one cycle with both gates off. The stimulus changes inputs only on falling clock edges. Its request sequences include immediate reversals and requests for both switches, and it uses a pseudo-random phase in which faults are rare and each fault lasts a few cycles. This keeps every dead-time window and every lockout recovery within the cases the properties describe.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef struct packed {
    logic hs;
    logic ls;
  } leg_gate_t;
endpackage

// File: rtl/hb_supply_guard.sv
module hb_supply_guard (
  input  logic uv_logic_i,
  input  logic uv_drv_i,
  input  logic ov_i,
  input  logic ov_lock_en_i,
  output logic hold_off_o
);
  always_comb hold_off_o = uv_logic_i | uv_drv_i | (ov_i & ov_lock_en_i);
endmodule

// File: rtl/hb_leg_seq.sv
module hb_leg_seq
  import hb_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 50,
  localparam int unsigned CW = $clog2(DEAD_CYC + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_hs_i,
  input  logic      req_ls_i,
  input  logic      hold_i,
  input  logic      kill_i,
  output leg_gate_t gate_o
);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

  leg_gate_t       gate_q, gate_d;
  logic [CW-1:0]   hs_wait_q, ls_wait_q;
  logic            want_hs, want_ls, hs_ok, ls_ok;

  always_comb begin
    want_hs = req_hs_i & ~hold_i & ~kill_i;
    want_ls = req_ls_i & ~req_hs_i & ~hold_i & ~kill_i; // high side wins
    hs_ok   = ~gate_q.ls & (ls_wait_q == '0);
    ls_ok   = ~gate_q.hs & (hs_wait_q == '0);
    gate_d.hs = want_hs & (gate_q.hs | hs_ok);
    gate_d.ls = want_ls & (gate_q.ls | ls_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= '0;
      hs_wait_q <= '0;
      ls_wait_q <= '0;
    end else begin
      gate_q <= gate_d;
      if (gate_q.hs & ~gate_d.hs)  hs_wait_q <= LOAD;
      else if (hs_wait_q != '0)    hs_wait_q <= hs_wait_q - 1'b1;
      if (gate_q.ls & ~gate_d.ls)  ls_wait_q <= LOAD;
      else if (ls_wait_q != '0)    ls_wait_q <= ls_wait_q - 1'b1;
    end
  end

  assign gate_o = gate_q;

  // independent quiet-time counters for the gap checks
  logic [CW-1:0] hs_quiet_q, ls_quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_quiet_q <= CW'(DEAD_CYC);
      ls_quiet_q <= CW'(DEAD_CYC);
    end else begin
      if (gate_q.hs) hs_quiet_q <= '0;
      else if (hs_quiet_q != CW'(DEAD_CYC)) hs_quiet_q <= hs_quiet_q + 1'b1;
      if (gate_q.ls) ls_quiet_q <= '0;
      else if (ls_quiet_q != CW'(DEAD_CYC)) ls_quiet_q <= ls_quiet_q + 1'b1;
    end
  end

  // R2
  no_shoot_thru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o.hs && gate_o.ls));
  // R3
  ls_to_hs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o.hs) |-> ls_quiet_q >= CW'(DEAD_CYC));
  // R4
  hs_to_ls_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o.ls) |-> hs_quiet_q >= CW'(DEAD_CYC));
  // R9
  kill_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (!gate_o.hs && !gate_o.ls));
  // R6
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!gate_o.hs && !gate_o.ls));
  // R10
  both_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_hs_i && req_ls_i) |=> !gate_o.ls);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int unsigned N_LEGS  = 3,
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned DEAD_NS = 1000,
  localparam int unsigned DEAD_RAW = ((CLK_HZ / 1000) * DEAD_NS) / 1_000_000,
  localparam int unsigned DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LEGS-1:0] req_hs_i,
  input  logic [N_LEGS-1:0] req_ls_i,
  input  logic              uv_logic_i,
  input  logic              uv_drv_i,
  input  logic              ov_i,
  input  logic              ov_lock_en_i,
  input  logic [N_LEGS-1:0] leg_kill_i,
  output logic [N_LEGS-1:0] gate_hs_o,
  output logic [N_LEGS-1:0] gate_ls_o
);
  logic hold_off;

  hb_supply_guard i_guard (
    .uv_logic_i  (uv_logic_i),
    .uv_drv_i    (uv_drv_i),
    .ov_i        (ov_i),
    .ov_lock_en_i(ov_lock_en_i),
    .hold_off_o  (hold_off)
  );

  for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
    leg_gate_t gate;
    hb_leg_seq #(.DEAD_CYC(DEAD_CYC)) i_leg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_hs_i(req_hs_i[g]),
      .req_ls_i(req_ls_i[g]),
      .hold_i  (hold_off),
      .kill_i  (leg_kill_i[g]),
      .gate_o  (gate)
    );
    assign gate_hs_o[g] = gate.hs;
    assign gate_ls_o[g] = gate.ls;
  end

  // R7
  ov_gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_i && ov_lock_en_i) |=> (gate_hs_o == '0 && gate_ls_o == '0));
endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 3;
  localparam int DEAD = 50;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NL-1:0] req_hs = '0, req_ls = '0, kill = '0;
  logic uv_l = 1'b0, uv_d = 1'b0, ov = 1'b0, ov_en = 1'b0;
  logic [NL-1:0] g_hs, g_ls;

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_gate_seq #(.N_LEGS(NL), .CLK_HZ(50_000_000), .DEAD_NS(1000)) i_hb_gate_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_hs_i(req_hs), .req_ls_i(req_ls),
    .uv_logic_i(uv_l), .uv_drv_i(uv_d), .ov_i(ov), .ov_lock_en_i(ov_en),
    .leg_kill_i(kill), .gate_hs_o(g_hs), .gate_ls_o(g_ls)
  );

  // behavioural reference: per-leg state plus edges since each gate fell
  bit m_hs[NL], m_ls[NL];
  int since_hs[NL], since_ls[NL];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) begin
        m_hs[i] = 0; m_ls[i] = 0; since_hs[i] = DEAD; since_ls[i] = DEAD;
      end
    end else begin
      bit hold;
      hold = uv_l || uv_d || (ov && ov_en);
      for (int i = 0; i < NL; i++) begin
        bit wh, wl, nh, nl;
        wh = req_hs[i] && !hold && !kill[i];
        wl = req_ls[i] && !req_hs[i] && !hold && !kill[i];
        nh = wh && (m_hs[i] || (!m_ls[i] && since_ls[i] >= DEAD));
        nl = wl && (m_ls[i] || (!m_hs[i] && since_hs[i] >= DEAD));
        if (m_hs[i] && !nh) since_hs[i] = 1;
        else if (since_hs[i] < DEAD) since_hs[i]++;
        if (m_ls[i] && !nl) since_ls[i] = 1;
        else if (since_ls[i] < DEAD) since_ls[i]++;
        m_hs[i] = nh; m_ls[i] = nl;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      for (int i = 0; i < NL; i++) begin
        total++;
        if (g_hs[i] !== m_hs[i] || g_ls[i] !== m_ls[i]) begin
          bad++;
          $display("FAIL %s leg%0d hs/ls actual=%b%b expected=%b%b at %0t",
                   cur_req, i, g_hs[i], g_ls[i], m_hs[i], m_ls[i], $time);
        end
        total++;
        if (g_hs[i] && g_ls[i]) begin
          bad++;
          $display("FAIL R2 leg%0d both on actual=11 expected=not 11", i);
        end
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_leg(int leg, bit hs, bit ls, string tag);
    total++;
    if (g_hs[leg] !== hs || g_ls[leg] !== ls) begin
      bad++;
      $display("FAIL %s leg%0d actual=%b%b expected=%b%b", tag, leg,
               g_hs[leg], g_ls[leg], hs, ls);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lfsr;
    wait_n(3);
    // R1
    for (int i = 0; i < NL; i++) expect_leg(i, 0, 0, "R1 in reset");
    rst_ni = 1'b1;
    wait_n(2);
    for (int i = 0; i < NL; i++) expect_leg(i, 0, 0, "R1 after reset");

    // R5 immediate turn-on
    cur_req = "R5";
    req_hs[0] = 1; req_ls[1] = 1;
    wait_n(1);
    expect_leg(0, 1, 0, "R5 hs on");
    expect_leg(1, 0, 1, "R5 ls on");

    // R4 hs -> ls handover on leg0
    cur_req = "R4";
    req_hs[0] = 0; req_ls[0] = 1;
    wait_n(1);
    expect_leg(0, 0, 0, "R4 hs off next edge");
    wait_n(DEAD - 1);
    expect_leg(0, 0, 0, "R4 still in gap");
    wait_n(1);
    expect_leg(0, 0, 1, "R4 ls on after gap");

    // R3 ls -> hs handover on leg0
    cur_req = "R3";
    req_ls[0] = 0; req_hs[0] = 1;
    wait_n(1);
    expect_leg(0, 0, 0, "R3 ls off next edge");
    wait_n(DEAD - 1);
    expect_leg(0, 0, 0, "R3 still in gap");
    wait_n(1);
    expect_leg(0, 1, 0, "R3 hs on after gap");

    // R10 both requested on idle leg2
    cur_req = "R10";
    req_hs[2] = 1; req_ls[2] = 1;
    wait_n(1);
    expect_leg(2, 1, 0, "R10 only hs");
    req_hs[2] = 0; req_ls[2] = 0;
    wait_n(DEAD + 2);

    // R6 undervoltage on each supply, R8 resume
    cur_req = "R6";
    uv_l = 1;
    wait_n(1);
    expect_leg(0, 0, 0, "R6 uv logic"); expect_leg(1, 0, 0, "R6 uv logic");
    wait_n(4);
    cur_req = "R8";
    uv_l = 0;
    wait_n(1);
    expect_leg(0, 1, 0, "R8 resume after uv"); expect_leg(1, 0, 1, "R8 resume after uv");
    cur_req = "R6";
    uv_d = 1;
    wait_n(1);
    expect_leg(0, 0, 0, "R6 uv drv"); expect_leg(1, 0, 0, "R6 uv drv");
    uv_d = 0;
    wait_n(2);

    // R7 overvoltage, enable off then on
    cur_req = "R7";
    ov = 1;
    wait_n(3);
    expect_leg(0, 1, 0, "R7 ov ignored"); expect_leg(1, 0, 1, "R7 ov ignored");
    ov_en = 1;
    wait_n(1);
    expect_leg(0, 0, 0, "R7 ov lockout"); expect_leg(1, 0, 0, "R7 ov lockout");
    // request change during lockout: dead time still applies on resume
    req_hs[1] = 1; req_ls[1] = 0;
    wait_n(3);
    cur_req = "R8";
    ov = 0;
    wait_n(1);
    expect_leg(0, 1, 0, "R8 resume after ov");
    wait_n(DEAD + 2);
    ov_en = 0;

    // R9 per-leg kill
    cur_req = "R9";
    kill[1] = 1;
    wait_n(1);
    expect_leg(1, 0, 0, "R9 kill leg1");
    expect_leg(0, 1, 0, "R9 leg0 untouched");
    kill[1] = 0;
    wait_n(2);

    // R11 H-bridge on legs 0/1, leg2 independent high-side switch
    cur_req = "R11";
    req_hs = 3'b001; req_ls = 3'b010; // forward
    wait_n(DEAD + 3);
    expect_leg(0, 1, 0, "R11 forward"); expect_leg(1, 0, 1, "R11 forward");
    req_hs = 3'b110; req_ls = 3'b001; // reverse + leg2 on
    wait_n(1);
    expect_leg(2, 1, 0, "R11 leg2 independent");
    wait_n(DEAD + 2);
    expect_leg(0, 0, 1, "R11 reverse"); expect_leg(1, 1, 0, "R11 reverse");
    req_hs = 3'b100; req_ls = 3'b011; // brake
    wait_n(DEAD + 3);
    expect_leg(0, 0, 1, "R11 brake"); expect_leg(1, 0, 1, "R11 brake");
    req_hs = '0; req_ls = '0; // high impedance
    wait_n(2);
    expect_leg(0, 0, 0, "R11 hiz"); expect_leg(1, 0, 0, "R11 hiz");

    // pseudo-random mix, checked by the reference every cycle
    cur_req = "R3 R4 R11";
    lfsr = 32'h1d2c3b4a;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      req_hs = lfsr[2:0];
      req_ls = lfsr[5:3];
      kill   = (lfsr[11:8] == 4'h0) ? lfsr[14:12] : '0;
      uv_l   = (lfsr[19:15] == 5'h0);
      ov     = lfsr[20];
      ov_en  = (lfsr[25:22] == 4'h0);
      wait_n(1 + (lfsr[29:26] == 4'h0 ? DEAD : lfsr[27:26]));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule